// File: doc/BRIEF.md
# Indirect Command/Data Register Port

This block is the processor-facing programmed-I/O front end of a combined host/device controller. The processor sees four 16-bit ports, chosen by an active-low chip select and a two-bit address. The host controller owns one command port and one data port, and the device controller owns the other pair. Registers are never addressed directly. The processor first writes an 8-bit register code to a side's command port. It then reaches that register through the same side's data port.

Bit 7 of the latched code gives the direction of the data-port access that follows. When bit 7 is set, the code opens the register for writing. When bit 7 is clear, the same register is opened for reading, so a read code and its write code differ only in that bit. Each side holds its own latched code and a small parameterised bank of 16-bit registers, which here stand in for the DMA configuration and transfer count. Codes outside a side's bank read as zero, and writes to them are dropped.

All bus strobes are sampled by the block clock. A write takes effect when the write strobe returns high. Read data is combinational and is qualified by an output-enable.

Top module: `pio_regport`

## Requirements
- R1: While `cs_n` is high, no port is decoded. A write pulse changes no latched code and no register, and a read leaves `rdata_oe` low.
- R2: Address map: `addr`=00 is the host data port, 01 the host command port, 10 the device data port and 11 the device command port.
- R3: A read of either command port (`addr[0]`=1) returns zero and leaves that side's latched code unchanged.
- R4: A write is captured when `wr_n` returns high. The stored value is the `wdata`, `addr` and `cs_n` present in the last clock cycle in which `wr_n` was low. The latched code never changes in the clock after a cycle with `wr_n` low.
- R5: With a latched code whose bit 7 is set and whose bits 6:0 equal BASE+k, for k below N_REGS, a data-port write stores `wdata` into register k of that side.
- R6: A data-port write is discarded when the side's latched code has bit 7 clear.
- R7: A data-port read returns register k when the latched code is BASE+k with bit 7 clear. It returns zero when bit 7 of the latched code is set.
- R8: A code whose bits 6:0 fall outside BASE to BASE+N_REGS-1 reads as zero, and data writes made under it are discarded.
- R9: The host and device sides keep separate latched codes and separate register banks. An access on one side never alters the other side.
- R10: `rdata_oe` is high only while `cs_n` and `rd_n` are both low, and `rdata` is zero whenever `rdata_oe` is low.
- R11: After reset, both latched codes are 00h and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock sampling the bus strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe, committed on its rising edge |
| addr | input | 2 | Port select: bit 1 picks the side, bit 0 picks command |
| wdata | input | DW (16) | Write data from the processor |
| rdata | output | DW (16) | Read data, zero when not enabled |
| rdata_oe | output | 1 | Bus drive enable for `rdata` |

## Verification
The checker watches the combinational read path on every cycle. It confirms that command-port reads and write-mode data reads return zero, that the bus is quiet whenever the output enable is low, that chip select high keeps the enable low, and that neither latched code moves while the write strobe is held low. Register contents and the write-to-read sequence can only be shown by the bench's scenarios. These cover the sweep of every code on both sides, data captured from the final low cycle of a strobe, writes blocked by a read-mode code or by a deasserted chip select, and the independence of the two sides.

// File: rtl/pio_regport_pkg.sv
package pio_regport_pkg;
   localparam int CODE_W   = 8;
   localparam int CODE_IDX = CODE_W - 1;

   typedef enum logic [1:0] {
      PORT_HOST_DATA = 2'b00,
      PORT_HOST_CMD  = 2'b01,
      PORT_DEV_DATA  = 2'b10,
      PORT_DEV_CMD   = 2'b11
   } port_e;

   function automatic logic port_is_cmd(input logic [1:0] a);
      return a[0];
   endfunction

   function automatic logic port_side(input logic [1:0] a);
      return a[1];
   endfunction
endpackage

// File: rtl/pio_bus_front.sv
module pio_bus_front #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          wr_n,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic          commit,
   output logic [1:0]    commit_addr,
   output logic [DW-1:0] commit_data
);
   logic          wr_q;
   logic          hold_sel;
   logic [1:0]    hold_addr;
   logic [DW-1:0] hold_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q      <= 1'b1;
         hold_sel  <= 1'b0;
         hold_addr <= '0;
         hold_data <= '0;
      end else begin
         wr_q <= wr_n;
         if (!wr_n) begin
            hold_sel  <= !cs_n;
            hold_addr <= addr;
            hold_data <= wdata;
         end
      end
   end

   assign commit      = !wr_q && wr_n && hold_sel;
   assign commit_addr = hold_addr;
   assign commit_data = hold_data;
endmodule

// File: rtl/pio_side.sv
module pio_side #(
   parameter int DW     = 16,
   parameter int N_REGS = 4,
   parameter int BASE   = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          code_we,
   input  logic          data_we,
   input  logic [DW-1:0] wdata,
   output logic [7:0]    code_q,
   output logic [DW-1:0] rd_value
);
   localparam int IDX_W = $clog2(N_REGS);

   logic [6:0]    offset;
   logic          hit;
   logic [DW-1:0] bank [N_REGS];

   assign offset = code_q[6:0] - 7'(BASE);
   assign hit    = (offset < 7'(N_REGS));

   always_ff @(posedge clk) begin
      if (!rst_n)       code_q <= '0;
      else if (code_we) code_q <= wdata[7:0];
   end

   for (genvar k = 0; k < N_REGS; k++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank[k] <= '0;
         else if (data_we && code_q[7] && hit && offset == 7'(k))
            bank[k] <= wdata;
      end
   end

   always_comb begin
      rd_value = '0;
      if (!code_q[7] && hit)
         rd_value = bank[offset[IDX_W-1:0]];
   end
endmodule

// File: rtl/pio_regport.sv
module pio_regport #(
   parameter int DW        = 16,
   parameter int N_REGS    = 4,
   parameter int HOST_BASE = 32,
   parameter int DEV_BASE  = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cs_n,
   input  logic          rd_n,
   input  logic          wr_n,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          rdata_oe
);
   import pio_regport_pkg::*;

   if (DW < CODE_W) begin : g_bad_dw
      $error("pio_regport: DW must hold an 8-bit code");
   end
   if (N_REGS < 2 || N_REGS > 64) begin : g_bad_n
      $error("pio_regport: N_REGS out of range");
   end
   if (HOST_BASE + N_REGS > 128 || DEV_BASE + N_REGS > 128) begin : g_bad_base
      $error("pio_regport: register bank exceeds 7-bit code space");
   end

   logic          commit;
   logic [1:0]    commit_addr;
   logic [DW-1:0] commit_data;
   logic [7:0]    side_code [2];
   logic [DW-1:0] side_rd   [2];
   logic [7:0]    host_cmd;
   logic [7:0]    dev_cmd;
   logic          rd_act;

   pio_bus_front #(.DW(DW)) u_front (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata),
      .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
   );

   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam int SBASE = (s == 0) ? HOST_BASE : DEV_BASE;
      logic mine;
      assign mine = commit && (port_side(commit_addr) == 1'(s));
      pio_side #(.DW(DW), .N_REGS(N_REGS), .BASE(SBASE)) u_side (
         .clk(clk), .rst_n(rst_n),
         .code_we(mine && port_is_cmd(commit_addr)),
         .data_we(mine && !port_is_cmd(commit_addr)),
         .wdata(commit_data),
         .code_q(side_code[s]),
         .rd_value(side_rd[s])
      );
   end

   assign host_cmd = side_code[0];
   assign dev_cmd  = side_code[1];

   assign rd_act   = !cs_n && !rd_n;
   assign rdata_oe = rd_act;
   assign rdata    = (rd_act && !port_is_cmd(addr)) ? side_rd[port_side(addr)] : '0;
endmodule

// File: rtl/pio_regport_chk.sv
module pio_regport_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          rd_n,
   input logic          wr_n,
   input logic [1:0]    addr,
   input logic [DW-1:0] rdata,
   input logic          rdata_oe,
   input logic [7:0]    host_cmd,
   input logic [7:0]    dev_cmd
);
   AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !rdata_oe |-> rdata == '0); // R10
   AST_DESELECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !rdata_oe); // R1
   AST_CMD_PORT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && addr[0]) |-> rdata == '0); // R3
   AST_HOST_WMODE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && addr == 2'b00 && host_cmd[7]) |-> rdata == '0); // R7
   AST_DEV_WMODE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !rd_n && addr == 2'b10 && dev_cmd[7]) |-> rdata == '0); // R7
   AST_HOST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |=> $stable(host_cmd)); // R4
   AST_DEV_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_n |=> $stable(dev_cmd)); // R4
endmodule

bind pio_regport pio_regport_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
   .addr(addr), .rdata(rdata), .rdata_oe(rdata_oe),
   .host_cmd(host_cmd), .dev_cmd(dev_cmd)
);

// File: tb/tb_pio_regport.sv
module tb_pio_regport;
   localparam int DW = 16;
   localparam int NR = 4;
   localparam int BASE = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic [1:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          rdata_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [DW-1:0] exp_bank [2][NR];

   always #5 clk = ~clk;

   pio_regport #(.DW(DW), .N_REGS(NR), .HOST_BASE(BASE), .DEV_BASE(BASE)) dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d, input logic sel);
      @(negedge clk); cs_n = !sel; addr = a; wdata = d; wr_n = 1'b0;
      @(negedge clk); wr_n = 1'b1;
      @(negedge clk); cs_n = 1'b1;
   endtask

   task automatic bus_read(input logic [1:0] a, input logic sel,
                           output logic [DW-1:0] d, output logic oe);
      @(negedge clk); cs_n = !sel; addr = a; rd_n = 1'b0;
      #1; d = rdata; oe = rdata_oe;
      @(negedge clk); rd_n = 1'b1; cs_n = 1'b1;
   endtask

   function automatic logic [DW-1:0] pat(input int s, input int c);
      return DW'(((s + 1) * 16'h1357) ^ (c * 16'h0203) ^ 16'h8000);
   endfunction

   initial begin
      logic [DW-1:0] d;
      logic oe;
      for (int s = 0; s < 2; s++)
         for (int k = 0; k < NR; k++) exp_bank[s][k] = '0;

      repeat (3) @(negedge clk);
      chk("R10 oe low in reset", {15'd0, rdata_oe}, 16'd0);
      rst_n = 1'b1;

      // R11: reset state, code 00h reads zero, every register zero
      bus_read(2'b00, 1'b1, d, oe); chk("R11 host code 00h", d, 16'd0);
      bus_read(2'b10, 1'b1, d, oe); chk("R11 dev code 00h", d, 16'd0);
      for (int s = 0; s < 2; s++)
         for (int k = 0; k < NR; k++) begin
            bus_write({1'(s), 1'b1}, 16'(BASE + k), 1'b1);
            bus_read({1'(s), 1'b0}, 1'b1, d, oe);
            chk("R11 register zero after reset", d, 16'd0);
         end

      // R2/R5/R7/R8: sweep every 7-bit code on both sides
      for (int s = 0; s < 2; s++)
         for (int c = 0; c < 128; c++) begin
            bit in_bank;
            logic [DW-1:0] e;
            in_bank = (c >= BASE) && (c < BASE + NR);
            bus_write({1'(s), 1'b1}, 16'(c | 8'h80), 1'b1);
            bus_write({1'(s), 1'b0}, pat(s, c), 1'b1);
            if (in_bank) exp_bank[s][c - BASE] = pat(s, c);
            bus_read({1'(s), 1'b0}, 1'b1, d, oe);
            chk("R7 write-mode data read is zero", d, 16'd0);
            bus_write({1'(s), 1'b1}, 16'(c), 1'b1);
            bus_read({1'(s), 1'b0}, 1'b1, d, oe);
            e = in_bank ? exp_bank[s][c - BASE] : 16'd0;
            chk(in_bank ? "R5 R2 stored register readback" : "R8 unimplemented code reads zero", d, e);
         end

      // R9: host bank survived the device sweep
      for (int k = 0; k < NR; k++) begin
         bus_write(2'b01, 16'(BASE + k), 1'b1);
         bus_read(2'b00, 1'b1, d, oe);
         chk("R9 host bank independent", d, exp_bank[0][k]);
      end
      // R9: device write while host holds a read code
      bus_write(2'b01, 16'(BASE + 2), 1'b1);
      bus_write(2'b11, 16'(BASE + 2) | 16'h80, 1'b1);
      bus_write(2'b10, 16'hBEEF, 1'b1);
      exp_bank[1][2] = 16'hBEEF;
      bus_read(2'b00, 1'b1, d, oe); chk("R9 host code kept", d, exp_bank[0][2]);
      bus_write(2'b11, 16'(BASE + 2), 1'b1);
      bus_read(2'b10, 1'b1, d, oe); chk("R9 device write landed", d, 16'hBEEF);

      // R3: command port reads zero and leave the code in place
      bus_write(2'b01, 16'(BASE + 1), 1'b1);
      bus_read(2'b01, 1'b1, d, oe); chk("R3 host command read", d, 16'd0);
      bus_read(2'b11, 1'b1, d, oe); chk("R3 device command read", d, 16'd0);
      bus_read(2'b00, 1'b1, d, oe); chk("R3 code unchanged by command read", d, exp_bank[0][1]);

      // R6: data write under a read code is dropped
      bus_write(2'b00, 16'hDEAD, 1'b1);
      bus_read(2'b00, 1'b1, d, oe); chk("R6 write under read code dropped", d, exp_bank[0][1]);

      // R1: deselected accesses do nothing
      bus_write(2'b01, 16'(BASE + 1) | 16'h80, 1'b0);
      bus_read(2'b00, 1'b1, d, oe); chk("R1 deselected command write ignored", d, exp_bank[0][1]);
      bus_write(2'b01, 16'(BASE + 1) | 16'h80, 1'b1);
      bus_write(2'b00, 16'h1111, 1'b0);
      bus_write(2'b01, 16'(BASE + 1), 1'b1);
      bus_read(2'b00, 1'b1, d, oe); chk("R1 deselected data write ignored", d, exp_bank[0][1]);
      bus_read(2'b00, 1'b0, d, oe);
      chk("R1 deselected read oe", {15'd0, oe}, 16'd0);
      chk("R10 deselected read data", d, 16'd0);
      @(negedge clk); cs_n = 1'b0; addr = 2'b00; #1;
      chk("R10 oe low without read strobe", {15'd0, rdata_oe}, 16'd0);
      chk("R10 data zero without read strobe", rdata, 16'd0);
      bus_read(2'b00, 1'b1, d, oe);
      chk("R10 oe high during read", {15'd0, oe}, 16'd1);

      // R4: value from the last low cycle of the write strobe is stored
      bus_write(2'b01, 16'(BASE + 3) | 16'h80, 1'b1);
      @(negedge clk); cs_n = 1'b0; addr = 2'b00; wdata = 16'h1234; wr_n = 1'b0;
      @(negedge clk); wdata = 16'h4321;
      @(negedge clk); wr_n = 1'b1; wdata = 16'h9999;
      @(negedge clk); cs_n = 1'b1;
      exp_bank[0][3] = 16'h4321;
      bus_write(2'b01, 16'(BASE + 3), 1'b1);
      bus_read(2'b00, 1'b1, d, oe); chk("R4 capture at strobe rise", d, 16'h4321);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule